// File: doc/BRIEF.md
# MSI L1 Coherence Cache Controller

This block is the child-side coherence engine of a small first-level cache. Every address in a small address set has its own line. Each line holds a coherence state (I, S or M), a data word and a flag that records whether the line is waiting for its parent. Processor loads and stores arrive on a request port and are answered on a response port. The parent is reached through one outgoing and one incoming message channel. Each message carries a request/response flag, an address, a 2-bit target state and a data word.

A load that finds the line in S or M, or a store that finds it in M, completes in the cycle it is presented. Any other access is a miss. On a miss the controller asks the parent for the needed state and holds the processor request at the head of its queue until the grant arrives. The controller also does three other things. It accepts grants from the parent at any time. It answers downgrade requests from the parent, or discards them when the line is already low enough. It lets the surrounding cache give up a line of its own accord, for example to evict it.

Top module: `msi_l1_ctlr`

## Requirements
- R1: After reset every line is in I with no pending wait. No processor response, no outgoing message and no eviction acceptance is asserted while the inputs are idle.
- R2: A load whose line is in S (code 1) or M (code 2) asserts cpuRespValid with cpuRespAck=0 and the line's data, and is dequeued (cpuReqReady=1) in the same cycle.
- R3: A store hits only when its line is in M. It then asserts cpuRespValid with cpuRespAck=1 and cpuRespData=0, dequeues the request and writes cpuReqData into the line.
- R4: A miss on a line with no pending wait sends one upgrade request on the out channel. The request has outIsResp=0 (request), the line address, a target of S for a load or M for a store (I=0, S=1, M=2) and data 0. The processor request stays undequeued. While the wait is pending, no further request is sent for that line.
- R5: An incoming response (inIsResp=1) is always accepted. Its data is written only if the line was in I. The line then takes the response's state and its pending wait is cleared.
- R6: An incoming downgrade request to y on a line above y sends a response (outIsResp=1) to state y. The response carries the line data if the line was in M, and 0 otherwise. The line moves to y. With outReady low, the request is not accepted and the line is unchanged.
- R7: An incoming downgrade request to y on a line already at or below y is accepted with no outgoing message and no state change.
- R8: A voluntary downgrade to y on a line with no pending wait and a state above y is accepted with a response to y. The response carries data only when the line leaves M. The line then moves to y.
- R9: A voluntary downgrade on a line with a pending wait, or whose state is not above y, is accepted with no message and no state change.
- R10: While an incoming parent message is valid, no processor response is given and no eviction is accepted. While an eviction is valid, the processor request is not served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request present |
| cpuReqReady | output | 1 | Processor request dequeued (hit) |
| cpuReqStore | input | 1 | 1 = store, 0 = load |
| cpuReqAddr | input | ADDR_W | Processor address |
| cpuReqData | input | DATA_W | Store data |
| cpuRespValid | output | 1 | Processor response present |
| cpuRespReady | input | 1 | Processor response taken |
| cpuRespAck | output | 1 | 1 = store acknowledgement |
| cpuRespData | output | DATA_W | Load data |
| outValid | output | 1 | Message to parent valid |
| outReady | input | 1 | Parent takes message |
| outIsResp | output | 1 | 1 = response, 0 = request |
| outAddr | output | ADDR_W | Message address |
| outState | output | 2 | Target state code |
| outData | output | DATA_W | Message data |
| inValid | input | 1 | Message from parent valid |
| inReady | output | 1 | Message from parent accepted |
| inIsResp | input | 1 | 1 = response, 0 = request |
| inAddr | input | ADDR_W | Message address |
| inState | input | 2 | Target state code |
| inData | input | DATA_W | Message data |
| evictValid | input | 1 | Voluntary downgrade requested |
| evictReady | output | 1 | Voluntary downgrade accepted |
| evictAddr | input | ADDR_W | Line to downgrade |
| evictState | input | 2 | Target state |

## Verification
Some faults corrupt a line's state or wait flag. Such a fault surfaces at the next access to that line: a load that should hit sends a request instead, a store that should miss is acknowledged, or a downgrade is answered when it should be dropped. Each of these shows in the same combinational cycle the access is presented. Corrupted data shows only when the line is later read or leaves M. The bench therefore follows every state change with an access that exposes it, and keeps a full model of all lines across a long random mix.

// File: rtl/msi_l1_pkg.sv
package msi_l1_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } lineSt_t;

  // Write strobes from control to the line store
  typedef struct packed {
    logic upWr;     // apply a grant from the parent at inAddr
    logic dnWr;     // lower the line at inAddr to inState
    logic evWr;     // lower the line at evictAddr to evictState
    logic waitSet;  // mark the line at cpuAddr as waiting
    logic storeWr;  // write processor data at cpuAddr
  } strobe_t;
endpackage

// File: rtl/msi_l1_dp.sv
module msi_l1_dp
  import msi_l1_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [1:0]        inState,
  input  logic [DATA_W-1:0] inData,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [1:0]        evictState,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  output lineSt_t           stIn,
  output lineSt_t           stEv,
  output lineSt_t           stCpu,
  output logic              waitEv,
  output logic              waitCpu,
  output logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataEv,
  output logic [DATA_W-1:0] dataCpu
);
  localparam int NUM_LINES = 1 << ADDR_W;

  lineSt_t           stArr   [NUM_LINES];
  logic              waitArr [NUM_LINES];
  logic [DATA_W-1:0] dataArr [NUM_LINES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        stArr[i]   <= ST_I;
        waitArr[i] <= 1'b0;
        dataArr[i] <= '0;
      end
    end else begin
      if (strb.upWr) begin
        if (stArr[inAddr] == ST_I) dataArr[inAddr] <= inData;
        stArr[inAddr]   <= lineSt_t'(inState);
        waitArr[inAddr] <= 1'b0;
      end
      if (strb.dnWr)    stArr[inAddr]    <= lineSt_t'(inState);
      if (strb.evWr)    stArr[evictAddr] <= lineSt_t'(evictState);
      if (strb.waitSet) waitArr[cpuAddr] <= 1'b1;
      if (strb.storeWr) dataArr[cpuAddr] <= cpuData;
    end
  end

  assign stIn    = stArr[inAddr];
  assign stEv    = stArr[evictAddr];
  assign stCpu   = stArr[cpuAddr];
  assign waitEv  = waitArr[evictAddr];
  assign waitCpu = waitArr[cpuAddr];
  assign dataIn  = dataArr[inAddr];
  assign dataEv  = dataArr[evictAddr];
  assign dataCpu = dataArr[cpuAddr];
endmodule

// File: rtl/msi_l1_ctrl.sv
module msi_l1_ctrl
  import msi_l1_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              cpuReqValid,
  input  logic              cpuReqStore,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRespReady,
  input  logic              inValid,
  input  logic              inIsResp,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [1:0]        inState,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [1:0]        evictState,
  input  logic              outReady,
  input  lineSt_t           stIn,
  input  lineSt_t           stEv,
  input  lineSt_t           stCpu,
  input  logic              waitEv,
  input  logic              waitCpu,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] dataEv,
  input  logic [DATA_W-1:0] dataCpu,
  output strobe_t           strb,
  output logic              cpuReqReady,
  output logic              cpuRespValid,
  output logic              cpuRespAck,
  output logic [DATA_W-1:0] cpuRespData,
  output logic              inReady,
  output logic              evictReady,
  output logic              outValid,
  output logic              outIsResp,
  output logic [ADDR_W-1:0] outAddr,
  output logic [1:0]        outState,
  output logic [DATA_W-1:0] outData
);
  logic    inReq, inRsp, dnNeeded, quiet;
  logic    evTurn, evAllowed, cpuTurn, cpuHit, upNeeded;
  lineSt_t tgt;

  always_comb begin
    inReq     = inValid && !inIsResp;
    inRsp     = inValid && inIsResp;
    dnNeeded  = inReq && (stIn > inState);
    quiet     = !inValid;
    evTurn    = quiet && evictValid;
    evAllowed = !waitEv && (stEv > evictState);
    cpuTurn   = quiet && !evictValid && cpuReqValid;
    tgt       = cpuReqStore ? ST_M : ST_S;
    cpuHit    = cpuReqStore ? (stCpu == ST_M) : (stCpu != ST_I);
    upNeeded  = cpuTurn && !cpuHit && !waitCpu;

    inReady      = inRsp || (inReq && (!dnNeeded || outReady));
    evictReady   = evTurn && (!evAllowed || outReady);
    cpuRespValid = cpuTurn && cpuHit;
    cpuReqReady  = cpuRespValid && cpuRespReady;
    cpuRespAck   = cpuReqStore;
    cpuRespData  = cpuReqStore ? '0 : dataCpu;

    outValid  = 1'b0;
    outIsResp = 1'b0;
    outAddr   = '0;
    outState  = ST_I;
    outData   = '0;
    if (dnNeeded) begin
      outValid  = 1'b1;
      outIsResp = 1'b1;
      outAddr   = inAddr;
      outState  = inState;
      outData   = (stIn == ST_M) ? dataIn : '0;
    end else if (evTurn && evAllowed) begin
      outValid  = 1'b1;
      outIsResp = 1'b1;
      outAddr   = evictAddr;
      outState  = evictState;
      outData   = (stEv == ST_M) ? dataEv : '0;
    end else if (upNeeded) begin
      outValid  = 1'b1;
      outAddr   = cpuAddr;
      outState  = tgt;
    end

    strb.upWr    = inRsp;
    strb.dnWr    = dnNeeded && outReady;
    strb.evWr    = evTurn && evAllowed && outReady;
    strb.waitSet = upNeeded && outReady;
    strb.storeWr = cpuReqReady && cpuReqStore;
  end
endmodule

// File: rtl/msi_l1_ctlr.sv
module msi_l1_ctlr
  import msi_l1_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReqValid,
  output logic              cpuReqReady,
  input  logic              cpuReqStore,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W-1:0] cpuReqData,
  output logic              cpuRespValid,
  input  logic              cpuRespReady,
  output logic              cpuRespAck,
  output logic [DATA_W-1:0] cpuRespData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outIsResp,
  output logic [ADDR_W-1:0] outAddr,
  output logic [1:0]        outState,
  output logic [DATA_W-1:0] outData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inIsResp,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [1:0]        inState,
  input  logic [DATA_W-1:0] inData,
  input  logic              evictValid,
  output logic              evictReady,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [1:0]        evictState
);
  strobe_t           strb;
  lineSt_t           stIn, stEv, stCpu;
  logic              waitEv, waitCpu;
  logic [DATA_W-1:0] dataIn, dataEv, dataCpu;

  msi_l1_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inAddr(inAddr), .inState(inState), .inData(inData),
    .evictAddr(evictAddr), .evictState(evictState),
    .cpuAddr(cpuReqAddr), .cpuData(cpuReqData),
    .stIn(stIn), .stEv(stEv), .stCpu(stCpu),
    .waitEv(waitEv), .waitCpu(waitCpu),
    .dataIn(dataIn), .dataEv(dataEv), .dataCpu(dataCpu)
  );

  msi_l1_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .cpuReqValid(cpuReqValid), .cpuReqStore(cpuReqStore), .cpuAddr(cpuReqAddr),
    .cpuRespReady(cpuRespReady),
    .inValid(inValid), .inIsResp(inIsResp), .inAddr(inAddr), .inState(inState),
    .evictValid(evictValid), .evictAddr(evictAddr), .evictState(evictState),
    .outReady(outReady),
    .stIn(stIn), .stEv(stEv), .stCpu(stCpu),
    .waitEv(waitEv), .waitCpu(waitCpu),
    .dataIn(dataIn), .dataEv(dataEv), .dataCpu(dataCpu),
    .strb(strb),
    .cpuReqReady(cpuReqReady), .cpuRespValid(cpuRespValid),
    .cpuRespAck(cpuRespAck), .cpuRespData(cpuRespData),
    .inReady(inReady), .evictReady(evictReady),
    .outValid(outValid), .outIsResp(outIsResp), .outAddr(outAddr),
    .outState(outState), .outData(outData)
  );
endmodule

// File: rtl/msi_l1_chk.sv
module msi_l1_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuRespValid,
  input logic              evictReady,
  input logic              outValid,
  input logic              outReady,
  input logic              outIsResp,
  input logic [ADDR_W-1:0] outAddr,
  input logic [1:0]        outState,
  input logic [DATA_W-1:0] outData,
  input logic              inValid,
  input logic              inReady,
  input logic              inIsResp,
  input logic [ADDR_W-1:0] inAddr
);
  localparam int NUM_LINES = 1 << ADDR_W;

  // Lines with an upgrade request in flight, seen from the ports
  logic [NUM_LINES-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rstN) pend <= '0;
    else begin
      if (inValid && inIsResp) pend[inAddr] <= 1'b0;
      if (outValid && outReady && !outIsResp) pend[outAddr] <= 1'b1;
    end
  end

  AST_UPREQ_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outIsResp) |-> (outData == '0 && outState != 2'd0)); // R4

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outIsResp) |-> !pend[outAddr]); // R4

  AST_RESP_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inIsResp) |-> inReady); // R5

  AST_PARENT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (!cpuRespValid && !evictReady)); // R10
endmodule

bind msi_l1_ctlr msi_l1_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/msi_l1_ctlr_bench.sv
module msi_l1_ctlr_bench;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NL = 1 << AW;

  // 125 MHz: 8 time-unit period
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic cpuReqValid, cpuReqReady, cpuReqStore, cpuRespValid, cpuRespReady, cpuRespAck;
  logic [AW-1:0] cpuReqAddr, outAddr, inAddr, evictAddr;
  logic [DW-1:0] cpuReqData, cpuRespData, outData, inData;
  logic outValid, outReady, outIsResp, inValid, inReady, inIsResp, evictValid, evictReady;
  logic [1:0] outState, inState, evictState;

  msi_l1_ctlr #(.ADDR_W(AW), .DATA_W(DW)) u_msi_l1_ctlr (.*);

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [1:0]    refSt   [NL];
  logic          refWait [NL];
  logic [1:0]    refTgt  [NL];
  logic [DW-1:0] refData [NL];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic expHit(logic st, logic [1:0] s);
    return st ? (s == 2'd2) : (s != 2'd0);
  endfunction

  function automatic logic [DW-1:0] expDnData(logic [1:0] s, logic [DW-1:0] d);
    return (s == 2'd2) ? d : '0;
  endfunction

  task automatic idle();
    cpuReqValid = 0; cpuReqStore = 0; cpuReqAddr = '0; cpuReqData = '0; cpuRespReady = 1;
    outReady = 1; inValid = 0; inIsResp = 0; inAddr = '0; inState = 0; inData = '0;
    evictValid = 0; evictAddr = '0; evictState = 0;
  endtask

  task automatic cpuOp(logic st, logic [AW-1:0] a, logic [DW-1:0] d);
    logic hit;
    string tag;
    @(negedge clk);
    cpuReqValid = 1; cpuReqStore = st; cpuReqAddr = a; cpuReqData = d;
    #1;
    hit = expHit(st, refSt[a]);
    tag = hit ? (st ? "R3" : "R2") : "R4";
    chk(tag, "cpuRespValid", cpuRespValid, hit);
    chk(tag, "cpuReqReady", cpuReqReady, hit);
    if (hit) begin
      chk(tag, "cpuRespAck", cpuRespAck, st);
      chk(tag, "cpuRespData", cpuRespData, st ? '0 : refData[a]);
      chk(tag, "outValid on hit", outValid, 0);
    end else if (!refWait[a]) begin
      chk(tag, "outValid", outValid, 1);
      chk(tag, "outIsResp", outIsResp, 0);
      chk(tag, "outAddr", outAddr, a);
      chk(tag, "outState", outState, st ? 2'd2 : 2'd1);
      chk(tag, "outData", outData, 0);
    end else begin
      chk(tag, "no resend while pending", outValid, 0);
    end
    @(posedge clk); #1;
    if (hit) begin
      if (st) refData[a] = d;
    end else if (!refWait[a]) begin
      refWait[a] = 1; refTgt[a] = st ? 2'd2 : 2'd1;
    end
    cpuReqValid = 0;
  endtask

  task automatic parentResp(logic [AW-1:0] a, logic [1:0] y, logic [DW-1:0] d);
    @(negedge clk);
    inValid = 1; inIsResp = 1; inAddr = a; inState = y; inData = d;
    #1;
    chk("R5", "inReady", inReady, 1);
    chk("R5", "outValid", outValid, 0);
    @(posedge clk); #1;
    if (refSt[a] == 2'd0) refData[a] = d;
    refSt[a] = y; refWait[a] = 0;
    inValid = 0;
  endtask

  task automatic parentDn(logic [AW-1:0] a, logic [1:0] y, logic rdy);
    logic need;
    @(negedge clk);
    inValid = 1; inIsResp = 0; inAddr = a; inState = y; outReady = rdy;
    #1;
    need = refSt[a] > y;
    if (need) begin
      chk("R6", "inReady", inReady, rdy);
      chk("R6", "outValid", outValid, 1);
      chk("R6", "outIsResp", outIsResp, 1);
      chk("R6", "outAddr", outAddr, a);
      chk("R6", "outState", outState, y);
      chk("R6", "outData", outData, expDnData(refSt[a], refData[a]));
    end else begin
      chk("R7", "inReady", inReady, 1);
      chk("R7", "outValid", outValid, 0);
    end
    @(posedge clk); #1;
    if (need && rdy) refSt[a] = y;
    inValid = 0; outReady = 1;
  endtask

  task automatic evict(logic [AW-1:0] a, logic [1:0] y);
    logic ok;
    @(negedge clk);
    evictValid = 1; evictAddr = a; evictState = y;
    #1;
    ok = !refWait[a] && (refSt[a] > y);
    if (ok) begin
      chk("R8", "evictReady", evictReady, 1);
      chk("R8", "outValid", outValid, 1);
      chk("R8", "outIsResp", outIsResp, 1);
      chk("R8", "outAddr", outAddr, a);
      chk("R8", "outState", outState, y);
      chk("R8", "outData", outData, expDnData(refSt[a], refData[a]));
    end else begin
      chk("R9", "evictReady", evictReady, 1);
      chk("R9", "outValid", outValid, 0);
    end
    @(posedge clk); #1;
    if (ok) refSt[a] = y;
    evictValid = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NL; i++) begin
      refSt[i] = 0; refWait[i] = 0; refTgt[i] = 0; refData[i] = '0;
    end
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk); #1;
    chk("R1", "cpuRespValid idle", cpuRespValid, 0);
    chk("R1", "outValid idle", outValid, 0);
    chk("R1", "evictReady idle", evictReady, 0);
    chk("R1", "cpuReqReady idle", cpuReqReady, 0);
    for (int i = 0; i < NL; i++) cpuOp(0, i[AW-1:0], '0); // R1: every line misses

    // Directed: load miss, stall, grant to S, hit
    cpuOp(0, 3'd0, '0);               // R4 pending, no resend
    parentResp(3'd0, 2'd1, 16'hA5A5); // R5 data written from I
    cpuOp(0, 3'd0, '0);               // R2 load hit in S
    cpuOp(1, 3'd0, 16'h1111);         // R3 store miss in S, upgrade to M
    parentResp(3'd0, 2'd2, 16'hDEAD); // R5 data not written (line was S)
    cpuOp(0, 3'd0, '0);               // R2 expects A5A5
    cpuOp(1, 3'd0, 16'h1234);         // R3 store hit
    cpuOp(0, 3'd0, '0);               // R2 reads 1234
    parentDn(3'd0, 2'd1, 0);          // R6 backpressure: not accepted
    cpuOp(1, 3'd0, 16'h2222);         // still M: store hits
    parentDn(3'd0, 2'd1, 1);          // R6 M->S carries data
    parentDn(3'd0, 2'd1, 1);          // R7 already at S: dropped
    cpuOp(1, 3'd0, 16'h3333);         // R6 line now S: store misses
    evict(3'd0, 2'd0);                // R9 wait pending: ignored
    parentResp(3'd0, 2'd2, 16'h0);
    evict(3'd0, 2'd0);                // R8 M->I with data
    evict(3'd0, 2'd0);                // R9 already I
    cpuOp(0, 3'd0, '0);               // line is I: load misses

    // R10: parent message beats a processor hit and an eviction
    parentResp(3'd1, 2'd2, 16'h00F1); // line 1 pending from reset pass
    @(negedge clk);
    cpuReqValid = 1; cpuReqStore = 0; cpuReqAddr = 3'd1;
    inValid = 1; inIsResp = 1; inAddr = 3'd2; inState = 2'd1; inData = 16'h0022;
    #1;
    chk("R10", "cpuRespValid under parent msg", cpuRespValid, 0);
    chk("R10", "inReady", inReady, 1);
    @(posedge clk); #1;
    refSt[2] = 1; refWait[2] = 0; refData[2] = 16'h0022;
    inValid = 0;
    @(negedge clk);
    evictValid = 1; evictAddr = 3'd2; evictState = 2'd0;
    #1;
    chk("R10", "cpuRespValid under eviction", cpuRespValid, 0);
    chk("R8", "outData leaving S", outData, 0);
    @(posedge clk); #1;
    refSt[2] = 0;
    evictValid = 0; cpuReqValid = 0;

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] a;
      int r;
      a = AW'($urandom % NL);
      r = int'($urandom % 8);
      if (refWait[a] && r < 3) parentResp(a, refTgt[a], DW'($urandom));
      else case (r)
        0, 1, 2: cpuOp(0, a, '0);
        3, 4:    cpuOp(1, a, DW'($urandom));
        5:       parentDn(a, 2'($urandom % 2), 1'($urandom % 4 != 0));
        default: evict(a, 2'($urandom % 2));
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule